// File: doc/BRIEF.md
# USB Endpoint Automatic DMA Sequencer

This block runs automatic DMA across a series of USB data packets on one chosen endpoint. Software writes a control word (enable, automatic-mode request, transfer direction, a switch that ignores receive toggle mismatches, and an endpoint number), loads a packet count and seeds the expected DATA0/DATA1 toggle. The block then waits until the serial engine reports that no transaction is in progress and the endpoint has been flushed. After that it raises its ready/active flag and follows each packet completion strobe.

Every packet on the chosen endpoint inverts the tracked toggle. Packets that fail (a receive error, a transmit without acknowledge, or a toggle that differs from the expected one) and other stopping conditions set sticky status bits. Those bits are cleared by writing zero. Any sticky bit raises the interrupt request, ends automatic mode, and keeps the mode from starting again until software clears it. When automatic mode stops while a packet is still in flight, the block holds ready/active until that packet's completion strobe arrives. While the mode runs in the transmit direction, the tracked toggle replaces the endpoint's own toggle on the transmit path.

Top module: `usb_adma_ctrl`

## Requirements
- R1: After reset the status word, ready/active, next toggle and interrupt request are all 0.
- R2: Status bits 0 to 3 (halt done = bit 0, error = bit 1, count reached zero = bit 2, short packet = bit 3) are sticky. A status write clears each bit whose write data is 0 and leaves a bit whose write data is 1 unchanged. A hardware set in the same cycle as a clear wins. The interrupt request is 1 whenever any of these four bits is 1.
- R3: With enable and the automatic request both set and status bits 0 to 3 all clear, the block leaves idle and waits. Ready/active rises one cycle after the first cycle in which flush-done is seen. While any status bit 0 to 3 is set, the mode is not entered.
- R4: While active, any status bit 0 to 3 being set, a halt pulse, enable cleared or the automatic request cleared starts termination. Ready/active stays 1 until a completion strobe for the chosen endpoint arrives or the transfer-busy input is 0, and falls on the following cycle.
- R5: A toggle write loads next toggle on the next cycle. Every completion strobe for the chosen endpoint inverts it, in any state. A toggle write in the same cycle as a strobe wins.
- R6: The error bit (bit 1) sets on an engaged packet in any of these cases: a receive packet reports an error, or a transmit packet has no acknowledge, or the packet toggle differs from next toggle as it stood before that packet's inversion. For receive packets with ignore-toggle set to 1, a mismatch is not an error.
- R7: An engaged receive packet flagged short sets bit 3. Each engaged error-free packet decrements the loaded count, stopping at 0. The decrement from 1 to 0 sets bit 2.
- R8: A halt pulse sets bit 0 only once the sequencer is idle: on the next cycle if it is already idle, otherwise one cycle after it returns to idle.
- R9: The transmit toggle output equals next toggle while ready/active is 1 and the direction is transmit (direction bit 1). Otherwise it equals the endpoint toggle input.
- R10: The status word carries bits 0 to 3 as in R2, ready/active at bit 4 and next toggle at bit 5. Bits 6 and 7 read 0.
- R11: Completion strobes for any endpoint other than the chosen one change no status bit and leave next toggle unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_en | input | 1 | DMA enable |
| ctl_auto | input | 1 | Automatic-mode request |
| ctl_dir_tx | input | 1 | Direction, 1 = transmit, 0 = receive |
| ctl_ign_rx_tgl | input | 1 | 1 = receive toggle mismatches are not errors |
| ctl_ep | input | EP_W | Chosen endpoint number |
| tgl_we | input | 1 | Initial toggle write strobe |
| tgl_wdata | input | 1 | Initial toggle value |
| sw_halt | input | 1 | Software halt pulse |
| evt_we | input | 1 | Status write strobe |
| evt_wdata | input | 4 | Status write data for bits 0 to 3 |
| cnt_we | input | 1 | Packet count load strobe |
| cnt_wdata | input | CNT_W | Packet count load value |
| flush_ok | input | 1 | No transaction in progress and endpoint flushed |
| xfer_busy | input | 1 | A packet transfer is in flight |
| pkt_vld | input | 1 | Packet completion strobe |
| pkt_ep | input | EP_W | Endpoint of the completed packet |
| pkt_tgl | input | 1 | Toggle carried by the packet |
| pkt_err | input | 1 | Receive error flag |
| pkt_ack | input | 1 | Transmit acknowledge flag |
| pkt_short | input | 1 | Packet shorter than the full FIFO |
| ep_tgl | input | 1 | Endpoint's own transmit toggle |
| ready | output | 1 | Automatic mode ready/active |
| next_tgl | output | 1 | Expected toggle of the next packet |
| tx_tgl | output | 1 | Toggle for the transmit path |
| evt_rd | output | 8 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is termination while a packet is still in flight. The bench holds the transfer-busy input high, halts the active mode, and keeps the block draining for several cycles before delivering the late strobe. It then follows the halt bit as it appears one cycle after the return to idle. Same-cycle collisions are also forced on purpose: a toggle write with a packet strobe, and a status clear with an error set. Re-entry after sticky bits are cleared follows each stop, so that the checks against the reference model cover both directions and both settings of the ignore-toggle switch.

// File: rtl/usbadma_pkg.sv
package usbadma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WAIT   = 2'd1,
      ST_ACTIVE = 2'd2,
      ST_DRAIN  = 2'd3
   } adma_state_e;

   localparam int EV_HALT   = 0;
   localparam int EV_ERR    = 1;
   localparam int EV_CNT0   = 2;
   localparam int EV_SHORT  = 3;
   localparam int EV_RDY    = 4;
   localparam int EV_NTGL   = 5;
   localparam int EV_STICKY = 4;
   localparam int EV_W      = 8;
endpackage

// File: rtl/usbadma_toggle.sv
module usbadma_toggle #(
   parameter int EP_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            load_val,
   input  logic            pkt_vld,
   input  logic [EP_W-1:0] pkt_ep,
   input  logic [EP_W-1:0] ep_sel,
   output logic            ep_hit,
   output logic            ntgl
);
   assign ep_hit = pkt_vld && (pkt_ep == ep_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ntgl <= 1'b0;
      else if (load)   ntgl <= load_val;
      else if (ep_hit) ntgl <= ~ntgl;
   end

   // R5: software load beats a same-cycle hardware inversion
   p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (ntgl == $past(load_val)));
   // R5 / R11: only a chosen-endpoint strobe inverts the toggle
   p_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && ep_hit) |=> (ntgl != $past(ntgl)));
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !ep_hit) |=> $stable(ntgl));
endmodule

// File: rtl/usbadma_events.sv
module usbadma_events
   import usbadma_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [EV_STICKY-1:0] wdata,
   input  logic                 cnt_we,
   input  logic [CNT_W-1:0]     cnt_wdata,
   input  logic                 hit,
   input  logic                 dir_tx,
   input  logic                 ign_rx_tgl,
   input  logic                 ntgl,
   input  logic                 pkt_tgl,
   input  logic                 pkt_err,
   input  logic                 pkt_ack,
   input  logic                 pkt_short,
   input  logic                 halt_done,
   output logic [EV_STICKY-1:0] sticky
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [EV_STICKY-1:0] ev_set, keep, ev_d;
   logic [CNT_W-1:0]     cnt_q;
   logic                 mism, bad, dec;

   assign mism = (pkt_tgl != ntgl);
   assign bad  = dir_tx ? (!pkt_ack || mism) : (pkt_err || (mism && !ign_rx_tgl));
   assign dec  = hit && !bad && (cnt_q != '0);

   always_comb begin
      ev_set            = '0;
      ev_set[EV_HALT]   = halt_done;
      ev_set[EV_ERR]    = hit && bad;
      ev_set[EV_CNT0]   = dec && (cnt_q == CNT_ONE);
      ev_set[EV_SHORT]  = hit && !dir_tx && pkt_short;
   end

   assign keep = wr ? wdata : '1;

   generate
      if (SET_WINS) begin : g_set_wins
         assign ev_d = ev_set | (sticky & keep);
      end else begin : g_clr_wins
         assign ev_d = (ev_set | sticky) & keep;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky <= '0;
         cnt_q  <= '0;
      end else begin
         sticky <= ev_d;
         if (cnt_we)   cnt_q <= cnt_wdata;
         else if (dec) cnt_q <= cnt_q - CNT_ONE;
      end
   end

   // R2: without a zero in the write data no sticky bit can drop
   p_w1_noeffect_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr || (wdata == '1)) |=> ((sticky & $past(sticky)) == $past(sticky)));
   // R6: ignored receive mismatch on a clean packet never raises the error bit
   p_rx_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !dir_tx && ign_rx_tgl && !pkt_err && !sticky[EV_ERR]) |=> !sticky[EV_ERR]);
   // R7: short flag never comes from a transmit packet
   p_short_rx_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_tx && !sticky[EV_SHORT]) |=> !sticky[EV_SHORT]);
endmodule

// File: rtl/usbadma_fsm.sv
module usbadma_fsm
   import usbadma_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        auto_req,
   input  logic        sw_halt,
   input  logic        evt_any,
   input  logic        flush_ok,
   input  logic        xfer_busy,
   input  logic        ep_hit,
   output adma_state_e state,
   output logic        engaged,
   output logic        halt_done
);
   adma_state_e st_d;
   logic        hpend_q, stop;

   assign stop      = sw_halt || !en || !auto_req || evt_any;
   assign engaged   = (state == ST_ACTIVE) || (state == ST_DRAIN);
   assign halt_done = (state == ST_IDLE) && (sw_halt || hpend_q);

   always_comb begin
      st_d = state;
      unique case (state)
         ST_IDLE:   if (!sw_halt && en && auto_req && !evt_any) st_d = ST_WAIT;
         ST_WAIT:   if (stop) st_d = ST_IDLE;
                    else if (flush_ok) st_d = ST_ACTIVE;
         ST_ACTIVE: if (stop) st_d = ST_DRAIN;
         ST_DRAIN:  if (ep_hit || !xfer_busy) st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         hpend_q <= 1'b0;
      end else begin
         state   <= st_d;
         hpend_q <= (state == ST_IDLE) ? 1'b0 : (hpend_q || sw_halt);
      end
   end

   // R3: pending status blocks entry
   p_no_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && evt_any) |=> (state == ST_IDLE));
   // R3: no activation before flush-done
   p_flush_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !flush_ok) |=> (state != ST_ACTIVE));
   // R4: a status event ends the active phase
   p_stop_on_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACTIVE && evt_any) |=> (state == ST_DRAIN));
   // R4: draining waits for the in-flight packet
   p_drain_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DRAIN && xfer_busy && !ep_hit) |=> (state == ST_DRAIN));
endmodule

// File: rtl/usb_adma_ctrl.sv
module usb_adma_ctrl
   import usbadma_pkg::*;
#(
   parameter int EP_W     = 3,
   parameter int CNT_W    = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_we,
   input  logic                 ctl_en,
   input  logic                 ctl_auto,
   input  logic                 ctl_dir_tx,
   input  logic                 ctl_ign_rx_tgl,
   input  logic [EP_W-1:0]      ctl_ep,
   input  logic                 tgl_we,
   input  logic                 tgl_wdata,
   input  logic                 sw_halt,
   input  logic                 evt_we,
   input  logic [EV_STICKY-1:0] evt_wdata,
   input  logic                 cnt_we,
   input  logic [CNT_W-1:0]     cnt_wdata,
   input  logic                 flush_ok,
   input  logic                 xfer_busy,
   input  logic                 pkt_vld,
   input  logic [EP_W-1:0]      pkt_ep,
   input  logic                 pkt_tgl,
   input  logic                 pkt_err,
   input  logic                 pkt_ack,
   input  logic                 pkt_short,
   input  logic                 ep_tgl,
   output logic                 ready,
   output logic                 next_tgl,
   output logic                 tx_tgl,
   output logic [EV_W-1:0]      evt_rd,
   output logic                 irq
);
   generate
      if (EP_W < 1 || EP_W > 8) begin : g_bad_ep_w
         $error("EP_W must lie in 1..8");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
         $error("CNT_W must lie in 2..32");
      end
   endgenerate

   logic            en_q, auto_q, dir_q, ign_q;
   logic [EP_W-1:0] ep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         auto_q <= 1'b0;
         dir_q  <= 1'b0;
         ign_q  <= 1'b0;
         ep_q   <= '0;
      end else if (ctl_we) begin
         en_q   <= ctl_en;
         auto_q <= ctl_auto;
         dir_q  <= ctl_dir_tx;
         ign_q  <= ctl_ign_rx_tgl;
         ep_q   <= ctl_ep;
      end
   end

   adma_state_e          state;
   logic                 ep_hit, engaged, halt_done;
   logic [EV_STICKY-1:0] sticky;

   usbadma_toggle #(.EP_W(EP_W)) u_tgl (
      .clk(clk), .rst_n(rst_n), .load(tgl_we), .load_val(tgl_wdata),
      .pkt_vld(pkt_vld), .pkt_ep(pkt_ep), .ep_sel(ep_q),
      .ep_hit(ep_hit), .ntgl(next_tgl)
   );

   usbadma_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .en(en_q), .auto_req(auto_q), .sw_halt(sw_halt),
      .evt_any(|sticky), .flush_ok(flush_ok), .xfer_busy(xfer_busy),
      .ep_hit(ep_hit), .state(state), .engaged(engaged), .halt_done(halt_done)
   );

   usbadma_events #(.CNT_W(CNT_W), .SET_WINS(SET_WINS)) u_evt (
      .clk(clk), .rst_n(rst_n), .wr(evt_we), .wdata(evt_wdata),
      .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .hit(ep_hit && engaged),
      .dir_tx(dir_q), .ign_rx_tgl(ign_q), .ntgl(next_tgl), .pkt_tgl(pkt_tgl),
      .pkt_err(pkt_err), .pkt_ack(pkt_ack), .pkt_short(pkt_short),
      .halt_done(halt_done), .sticky(sticky)
   );

   assign ready  = engaged;
   assign irq    = |sticky;
   assign tx_tgl = (ready && dir_q) ? next_tgl : ep_tgl;

   always_comb begin
      evt_rd                  = '0;
      evt_rd[EV_STICKY-1:0]   = sticky;
      evt_rd[EV_RDY]          = ready;
      evt_rd[EV_NTGL]         = next_tgl;
   end

   // R3: ready rises only after flush-done was seen
   p_ready_needs_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(flush_ok));
   // R8: halt bit appears only out of idle
   p_halt_after_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_rd[EV_HALT]) |-> $past(state == ST_IDLE));
   // R2: interrupt request never drops without a status write
   p_irq_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !evt_we) |=> irq);
endmodule

// File: tb/usb_adma_ctrl_tb.sv
`timescale 1ns/1ps
module usb_adma_ctrl_tb;
   localparam int EP_W = 3;
   localparam int CNT_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_we = 0, ctl_en = 0, ctl_auto = 0, ctl_dir_tx = 0, ctl_ign_rx_tgl = 0;
   logic [EP_W-1:0] ctl_ep = '0;
   logic tgl_we = 0, tgl_wdata = 0, sw_halt = 0, evt_we = 0;
   logic [3:0] evt_wdata = '0;
   logic cnt_we = 0;
   logic [CNT_W-1:0] cnt_wdata = '0;
   logic flush_ok = 0, xfer_busy = 0, pkt_vld = 0;
   logic [EP_W-1:0] pkt_ep = '0;
   logic pkt_tgl = 0, pkt_err = 0, pkt_ack = 0, pkt_short = 0, ep_tgl = 0;
   logic ready, next_tgl, tx_tgl, irq;
   logic [7:0] evt_rd;

   always #10 clk = ~clk;

   usb_adma_ctrl #(.EP_W(EP_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_auto(ctl_auto),
      .ctl_dir_tx(ctl_dir_tx), .ctl_ign_rx_tgl(ctl_ign_rx_tgl), .ctl_ep(ctl_ep),
      .tgl_we(tgl_we), .tgl_wdata(tgl_wdata), .sw_halt(sw_halt), .evt_we(evt_we),
      .evt_wdata(evt_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .flush_ok(flush_ok),
      .xfer_busy(xfer_busy), .pkt_vld(pkt_vld), .pkt_ep(pkt_ep), .pkt_tgl(pkt_tgl),
      .pkt_err(pkt_err), .pkt_ack(pkt_ack), .pkt_short(pkt_short), .ep_tgl(ep_tgl),
      .ready(ready), .next_tgl(next_tgl), .tx_tgl(tx_tgl), .evt_rd(evt_rd), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int   m_mode;      // 0 idle, 1 waiting for flush, 2 active, 3 draining
   bit   m_en, m_auto, m_dir, m_ign, m_ntgl, m_hpend;
   int   m_ep, m_cnt;
   bit   m_st[4];     // halt, error, count zero, short

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_en = 0; m_auto = 0; m_dir = 0; m_ign = 0; m_ntgl = 0;
         m_hpend = 0; m_ep = 0; m_cnt = 0;
         foreach (m_st[i]) m_st[i] = 0;
      end else begin
         bit on_ep, took, wrong, badp, anyst, stopit, hdone;
         bit setb[4];
         int nmode;
         on_ep = pkt_vld && (int'(pkt_ep) == m_ep);
         took  = on_ep && (m_mode >= 2);
         wrong = (pkt_tgl != m_ntgl);
         badp  = m_dir ? (!pkt_ack || wrong) : (pkt_err || (wrong && !m_ign));
         anyst = m_st[0] || m_st[1] || m_st[2] || m_st[3];
         hdone = (m_mode == 0) && (sw_halt || m_hpend);
         stopit = sw_halt || !m_en || !m_auto || anyst;
         setb[0] = hdone;
         setb[1] = took && badp;
         setb[2] = took && !badp && (m_cnt == 1);
         setb[3] = took && !m_dir && pkt_short;
         for (int i = 0; i < 4; i++)
            m_st[i] = setb[i] || (m_st[i] && (evt_we ? evt_wdata[i] : 1'b1));
         if (cnt_we) m_cnt = int'(cnt_wdata);
         else if (took && !badp && m_cnt > 0) m_cnt = m_cnt - 1;
         nmode = m_mode;
         if (m_mode == 0 && !sw_halt && m_en && m_auto && !anyst) nmode = 1;
         else if (m_mode == 1 && stopit) nmode = 0;
         else if (m_mode == 1 && flush_ok) nmode = 2;
         else if (m_mode == 2 && stopit) nmode = 3;
         else if (m_mode == 3 && (on_ep || !xfer_busy)) nmode = 0;
         m_hpend = (m_mode == 0) ? 1'b0 : (m_hpend || sw_halt);
         m_mode = nmode;
         if (tgl_we) m_ntgl = tgl_wdata;
         else if (on_ep) m_ntgl = !m_ntgl;
         if (ctl_we) begin
            m_en = ctl_en; m_auto = ctl_auto; m_dir = ctl_dir_tx;
            m_ign = ctl_ign_rx_tgl; m_ep = int'(ctl_ep);
         end
      end
   end

   always @(negedge clk) begin
      #2;
      if (rst_n && !finished) begin
         bit e_rdy;
         e_rdy = (m_mode >= 2);
         chk("R3 ready vs model", {7'd0, ready}, {7'd0, e_rdy});
         chk("R5 next_tgl vs model", {7'd0, next_tgl}, {7'd0, m_ntgl});
         chk("R9 tx_tgl vs model", {7'd0, tx_tgl},
             {7'd0, (e_rdy && m_dir) ? m_ntgl : ep_tgl});
         chk("R10 status word vs model", evt_rd,
             {2'b00, m_ntgl, e_rdy, m_st[3], m_st[2], m_st[1], m_st[0]});
         chk("R2 irq vs model", {7'd0, irq},
             {7'd0, m_st[0] || m_st[1] || m_st[2] || m_st[3]});
      end
   end

   // ---------------- watchdog ----------------
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ctl_write(input bit en, input bit au, input bit dir, input bit ign, input int ep);
      ctl_en = en; ctl_auto = au; ctl_dir_tx = dir; ctl_ign_rx_tgl = ign;
      ctl_ep = EP_W'(ep); ctl_we = 1; tick(1); ctl_we = 0;
   endtask

   task automatic evt_write(input logic [3:0] d);
      evt_wdata = d; evt_we = 1; tick(1); evt_we = 0;
   endtask

   task automatic tgl_write(input bit v);
      tgl_wdata = v; tgl_we = 1; tick(1); tgl_we = 0;
   endtask

   task automatic packet(input int ep, input bit t, input bit er, input bit ak, input bit sh);
      pkt_ep = EP_W'(ep); pkt_tgl = t; pkt_err = er; pkt_ack = ak; pkt_short = sh;
      pkt_vld = 1; tick(1); pkt_vld = 0; pkt_err = 0; pkt_short = 0;
   endtask

   initial begin
      bit wv;
      tick(3);
      rst_n = 1;
      tick(1);
      chk("R1 status word after reset", evt_rd, 8'h00);
      chk("R1 ready after reset", {7'd0, ready}, 8'h00);
      chk("R1 irq after reset", {7'd0, irq}, 8'h00);
      chk("R1 next_tgl after reset", {7'd0, next_tgl}, 8'h00);

      tgl_write(1);
      chk("R5 toggle load", {7'd0, next_tgl}, 8'h01);

      // entry waits for flush-done
      cnt_wdata = 8'd3; cnt_we = 1; tick(1); cnt_we = 0;
      ctl_write(1, 1, 0, 0, 2);
      tick(4);
      chk("R3 no ready before flush-done", {7'd0, ready}, 8'h00);
      flush_ok = 1;
      tick(1);
      chk("R3 ready after flush-done", {7'd0, ready}, 8'h01);

      // receive run
      packet(2, 1, 0, 0, 0);
      chk("R5 invert on packet", {7'd0, next_tgl}, 8'h00);
      chk("R6 matching packet no error", {4'd0, evt_rd[3:0]}, 8'h00);
      packet(5, 1, 1, 0, 1);
      chk("R11 other endpoint keeps toggle", {7'd0, next_tgl}, 8'h00);
      chk("R11 other endpoint sets nothing", {4'd0, evt_rd[3:0]}, 8'h00);
      packet(2, 0, 0, 0, 0);
      packet(2, 1, 0, 0, 1);
      chk("R7 count zero and short", evt_rd, 8'h1C);
      chk("R2 irq from status", {7'd0, irq}, 8'h01);
      tick(2);
      chk("R4 terminated on status", {7'd0, ready}, 8'h00);
      tick(4);
      chk("R3 entry blocked by status", {7'd0, ready}, 8'h00);

      evt_write(4'hF);
      chk("R2 writing ones keeps bits", {4'd0, evt_rd[3:0]}, 8'h0C);
      evt_write(4'h0);
      chk("R2 writing zeros clears", {4'd0, evt_rd[3:0]}, 8'h00);
      tick(2);
      chk("R3 re-entry after clear", {7'd0, ready}, 8'h01);

      // receive mismatch, not ignored
      packet(2, 1, 0, 0, 0);
      chk("R6 rx toggle mismatch error", {7'd0, evt_rd[1]}, 8'h01);
      tick(3);
      chk("R4 stop after error", {7'd0, ready}, 8'h00);

      // receive mismatch, ignored
      ctl_write(1, 1, 0, 1, 2);
      evt_write(4'h0);
      tick(2);
      packet(2, 0, 0, 0, 0);
      chk("R6 ignored mismatch no error", {7'd0, evt_rd[1]}, 8'h00);
      chk("R6 ignored mismatch keeps running", {7'd0, ready}, 8'h01);
      packet(2, 0, 1, 0, 0);
      chk("R6 rx error flag", {7'd0, evt_rd[1]}, 8'h01);
      tick(3);

      // transmit
      ctl_write(1, 1, 1, 0, 2);
      evt_write(4'h0);
      tick(2);
      ep_tgl = 0;
      #1;
      chk("R9 override with next toggle 1", {7'd0, tx_tgl}, 8'h01);
      ep_tgl = 1;
      tgl_write(0);
      chk("R9 override with next toggle 0", {7'd0, tx_tgl}, 8'h00);
      packet(2, 0, 0, 1, 0);
      chk("R6 acked tx no error", {7'd0, evt_rd[1]}, 8'h00);
      packet(2, 1, 0, 0, 0);
      chk("R6 unacked tx error", {7'd0, evt_rd[1]}, 8'h01);
      tick(3);
      chk("R9 endpoint toggle when idle", {7'd0, tx_tgl}, 8'h01);

      // halt while a packet is in flight
      ctl_write(1, 1, 0, 1, 2);
      evt_write(4'h0);
      tick(2);
      xfer_busy = 1;
      sw_halt = 1; tick(1); sw_halt = 0;
      tick(3);
      chk("R4 drain holds ready", {7'd0, ready}, 8'h01);
      chk("R8 no halt bit while draining", {7'd0, evt_rd[0]}, 8'h00);
      packet(2, m_ntgl, 0, 0, 0);
      xfer_busy = 0;
      chk("R4 ready falls after strobe", {7'd0, ready}, 8'h00);
      chk("R8 halt bit waits for idle", {7'd0, evt_rd[0]}, 8'h00);
      tick(1);
      chk("R8 halt bit after idle", {7'd0, evt_rd[0]}, 8'h01);

      // halt while idle
      ctl_write(0, 0, 0, 1, 2);
      evt_write(4'h0);
      chk("R8 halt bit cleared", {7'd0, evt_rd[0]}, 8'h00);
      sw_halt = 1; tick(1); sw_halt = 0;
      chk("R8 halt in idle next cycle", {7'd0, evt_rd[0]}, 8'h01);

      // same-cycle collisions
      evt_write(4'h0);
      ctl_write(1, 1, 0, 0, 2);
      tick(2);
      chk("R3 active again", {7'd0, ready}, 8'h01);
      wv = m_ntgl;
      tgl_wdata = wv; tgl_we = 1;
      evt_wdata = 4'h0; evt_we = 1;
      packet(2, wv, 1, 0, 0);
      tgl_we = 0; evt_we = 0;
      chk("R5 write beats inversion", {7'd0, next_tgl}, {7'd0, wv});
      chk("R2 set beats clear", {7'd0, evt_rd[1]}, 8'h01);
      tick(4);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule